// File: doc/BRIEF.md
# Wide Register Write Collector

This block is the host-facing register unit of a device whose control registers are 128 bits wide and whose on-chip memory entries are 64 bits wide, while the host reaches it one 32-bit word per request. Writes to the lower words of a wide register are held in a staging buffer. The write to the top word commits the whole register in one cycle, so device logic never sees a half-updated value. Reads work the other way. Reading word 0 captures the full current value into a read shadow, and the upper words are then served from that shadow. This gives the host a consistent set of words even if the register changes between its reads.

A few pointer-style registers hold a single 32-bit word. Writes to them bypass the collector and take effect at once, so they can be issued while a wide collection is still open without disturbing it. The whole register set repeats in pages of 0x2000 bytes. The register storage is held inside the block and is visible to the host only through reads.

Top module: `wide_reg_collector`

## Requirements
- R1: After reset all register storage, the staging buffer and the read shadow are zero, `rd_valid` and `commit_err` are low, and `req_ready` is high at all times.
- R2: An accepted read (`req_valid` high, `req_write` low) is answered by `rd_valid` high with `rd_data` in the next cycle. `rd_valid` is low in every cycle that does not follow an accepted read.
- R3: Wide register i (i < WIDE_N) of page p sits at byte address p*0x2000 + i*16, with word k (0..3) at +k*4; address bits 1:0 are ignored. Writes to words 0..2 only stage data. The write to word 3 replaces all 128 bits with {word3, staged2, staged1, staged0}. Until that write, reads return the previous contents.
- R4: `commit_err` is high for exactly the cycle after a committing write (wide word 3 or memory upper word) when any lower word of that register has not been staged since its last commit or since collection switched to it. Otherwise `commit_err` is low.
- R5: An unstaged lower word is committed with the value last staged for that same register before its previous commit. If the collector has just switched to the register, the value is zero.
- R6: A wide or memory write that targets a different register than the one last collected discards the staged words and the record of which words were staged.
- R7: Word register n (n < DW_N) of page p sits in the low word at p*0x2000 + 0x800 + n*16. A write updates it at once, and an open collection keeps its staged words and progress (including in page 0).
- R8: A read of wide word 0 returns the current low word and captures all 128 bits into the shadow. Reads of words 1..3 return shadow bits [32k+31:32k], even if the register was rewritten after the capture.
- R9: Memory entry i (i < SRAM_N) of page p sits at p*0x2000 + 0x1000 + i*8. A write to the lower word (+0) stages it, and a write to the upper word (+4) commits {upper, staged lower}. A read of the lower word returns it and captures all 64 bits into shadow bits [63:0]. A read of the upper word returns shadow bits [63:32].
- R10: Any other address, including pages at or above PAGES and the other words of a word-register slot, is ignored on write: no storage or collector change. On read it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address (page and offset) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| commit_err | output | 1 | Commit arrived with lower words missing |

## Verification
The assertions check the read response timing on every cycle. They also check that `commit_err` only ever follows a write, and that neither a word-register write nor a read moves the staged words or the staged-word record. Atomic commit contents, stale-word merging, discard on a change of target, snapshot consistency after a rewrite, page separation and unmapped addresses depend on sequences of requests. Only the bench's scenarios can show these, by comparing each read and error flag against a reference model.

// File: rtl/wide_reg_collector.sv
module wide_reg_collector #(
  parameter int PAGES  = 2,
  parameter int WIDE_N = 8,
  parameter int DW_N   = 3,
  parameter int SRAM_N = 8,
  localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int AW    = 13 + PG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic          commit_err
);
  localparam int WIDE_TOT = PAGES * WIDE_N;
  localparam int DW_TOT   = PAGES * DW_N;
  localparam int SRAM_TOT = PAGES * SRAM_N;
  localparam int WI_W = (WIDE_TOT > 1) ? $clog2(WIDE_TOT) : 1;
  localparam int DI_W = (DW_TOT > 1) ? $clog2(DW_TOT) : 1;
  localparam int SI_W = (SRAM_TOT > 1) ? $clog2(SRAM_TOT) : 1;
  localparam int TG_W = AW - 3;

  logic [127:0] wide_mem [WIDE_TOT];
  logic [63:0]  sram_mem [SRAM_TOT];
  logic [31:0]  dw_mem   [DW_TOT];

  logic [127:0]    stage, shadow;
  logic [3:0]      mask;
  logic [TG_W-1:0] tag;
  logic            tag_vld;

  logic [PG_W-1:0] pg;
  logic [12:0]     off;
  logic            pg_ok, wide_hit, dw_hit, sram_hit;
  logic [WI_W-1:0] wide_i;
  logic [DI_W-1:0] dw_i;
  logic [SI_W-1:0] sram_i;
  logic            wr, rd, coll_wr, sw, last, full;
  logic [1:0]      word;
  logic [TG_W-1:0] new_tag;
  logic [127:0]    stage_base, stage_nxt;
  logic [3:0]      mask_base, mask_nxt;
  logic [31:0]     rd_val;
  logic            unused_addr;

  assign req_ready   = 1'b1;
  assign unused_addr = ^req_addr[1:0];

  assign pg    = req_addr[AW-1:13];
  assign off   = req_addr[12:0];
  assign pg_ok = 32'(pg) < PAGES;

  assign wide_hit = pg_ok && off[12:11] == 2'b00 && 32'(off[10:4]) < WIDE_N;
  assign dw_hit   = pg_ok && off[12:11] == 2'b01 && 32'(off[10:4]) < DW_N && off[3:2] == 2'b00;
  assign sram_hit = pg_ok && off[12] && 32'(off[11:3]) < SRAM_N;

  assign wide_i = WI_W'(32'(pg) * WIDE_N + 32'(off[10:4]));
  assign dw_i   = DI_W'(32'(pg) * DW_N + 32'(off[10:4]));
  assign sram_i = SI_W'(32'(pg) * SRAM_N + 32'(off[11:3]));

  assign wr      = req_valid && req_write;
  assign rd      = req_valid && !req_write;
  assign coll_wr = wr && (wide_hit || sram_hit);

  assign new_tag = sram_hit ? req_addr[AW-1:3] : {req_addr[AW-1:4], 1'b0};
  assign sw      = !tag_vld || tag != new_tag;
  assign word    = sram_hit ? {1'b0, off[2]} : off[3:2];
  assign last    = sram_hit ? off[2] : (off[3:2] == 2'd3);

  assign stage_base = sw ? '0 : stage;
  assign mask_base  = sw ? '0 : mask;
  assign full       = sram_hit ? mask_base[0] : &mask_base[2:0];

  always_comb begin
    stage_nxt = stage_base;
    mask_nxt  = mask_base;
    if (!last) begin
      stage_nxt[{word, 5'd0} +: 32] = req_wdata;
      mask_nxt[word] = 1'b1;
    end else begin
      mask_nxt = '0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (wide_hit)
      rd_val = (word == 2'd0) ? wide_mem[wide_i][31:0] : shadow[{word, 5'd0} +: 32];
    else if (sram_hit)
      rd_val = off[2] ? shadow[63:32] : sram_mem[sram_i][31:0];
    else if (dw_hit)
      rd_val = dw_mem[dw_i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < WIDE_TOT; j++) wide_mem[j] <= '0;
      for (int j = 0; j < SRAM_TOT; j++) sram_mem[j] <= '0;
      for (int j = 0; j < DW_TOT; j++)   dw_mem[j]   <= '0;
      stage      <= '0;
      shadow     <= '0;
      mask       <= '0;
      tag        <= '0;
      tag_vld    <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      commit_err <= 1'b0;
    end else begin
      rd_valid   <= rd;
      commit_err <= coll_wr && last && !full;
      if (rd) begin
        rd_data <= rd_val;
        if (wide_hit && word == 2'd0) shadow <= wide_mem[wide_i];
        if (sram_hit && !off[2])      shadow <= {64'd0, sram_mem[sram_i]};
      end
      if (coll_wr) begin
        tag     <= new_tag;
        tag_vld <= 1'b1;
        stage   <= stage_nxt;
        mask    <= mask_nxt;
        if (last && wide_hit) wide_mem[wide_i] <= {req_wdata, stage_base[95:0]};
        if (last && sram_hit) sram_mem[sram_i] <= {req_wdata, stage_base[31:0]};
      end
      if (wr && dw_hit) dw_mem[dw_i] <= req_wdata;
    end
  end
endmodule

// File: rtl/wide_reg_collector_chk.sv
module wide_reg_collector_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_write,
  input logic         rd_valid,
  input logic         commit_err,
  input logic         dw_hit,
  input logic [127:0] stage,
  input logic [3:0]   mask
);
  a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  a_r4_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    commit_err |-> $past(req_valid && req_write));

  a_r7_word_write_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && dw_hit) |=> ($stable(stage) && $stable(mask)));

  a_r8_read_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> ($stable(stage) && $stable(mask)));
endmodule

bind wide_reg_collector wide_reg_collector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rd_valid(rd_valid), .commit_err(commit_err), .dw_hit(dw_hit),
  .stage(stage), .mask(mask)
);

// File: tb/sim_wide_reg_collector.sv
module sim_wide_reg_collector;
  localparam int PAGES = 2, WIDE_N = 8, DW_N = 3, SRAM_N = 8, AW = 14;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rd_valid, commit_err;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  wide_reg_collector u0 (.clk, .rst_n, .req_valid, .req_ready, .req_write,
    .req_addr, .req_wdata, .rd_valid, .rd_data, .commit_err);

  logic [127:0] m_wide [PAGES*WIDE_N];
  logic [63:0]  m_sram [PAGES*SRAM_N];
  logic [31:0]  m_dw   [PAGES*DW_N];
  logic [127:0] m_stage, m_shadow;
  logic [3:0]   m_mask;
  int           m_tag;
  bit           m_tag_vld;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wa(int p, int i, int k);
    return AW'(p * 'h2000 + i * 16 + k * 4);
  endfunction
  function automatic logic [AW-1:0] da(int p, int n);
    return AW'(p * 'h2000 + 'h800 + n * 16);
  endfunction
  function automatic logic [AW-1:0] sa(int p, int i, int h);
    return AW'(p * 'h2000 + 'h1000 + i * 8 + h * 4);
  endfunction

  task automatic access(bit w, logic [AW-1:0] a, logic [31:0] d, string req);
    int p, o, i, k, ntag;
    bit is_w, is_s, is_d, lastw, need;
    logic [31:0] exp_rd;
    bit exp_err;
    p = int'(a) / 'h2000;
    o = int'(a) % 'h2000;
    is_w = p < PAGES && o < 'h800 && (o / 16) < WIDE_N;
    is_d = p < PAGES && o >= 'h800 && o < 'h1000 && ((o - 'h800) / 16) < DW_N && ((o / 4) % 4) == 0;
    is_s = p < PAGES && o >= 'h1000 && ((o - 'h1000) / 8) < SRAM_N;
    exp_rd = 0;
    exp_err = 0;
    if (!w) begin
      if (is_w) begin
        i = p * WIDE_N + o / 16; k = (o / 4) % 4;
        exp_rd = (k == 0) ? m_wide[i][31:0] : m_shadow[k*32 +: 32];
        if (k == 0) m_shadow = m_wide[i];
      end else if (is_s) begin
        i = p * SRAM_N + (o - 'h1000) / 8; k = (o / 4) % 2;
        exp_rd = (k == 1) ? m_shadow[63:32] : m_sram[i][31:0];
        if (k == 0) m_shadow = {64'd0, m_sram[i]};
      end else if (is_d) begin
        exp_rd = m_dw[p * DW_N + (o - 'h800) / 16];
      end
    end else if (is_d) begin
      m_dw[p * DW_N + (o - 'h800) / 16] = d;
    end else if (is_w || is_s) begin
      ntag = is_s ? ('h100000 | (int'(a) / 8)) : (int'(a) / 16);
      if (!m_tag_vld || m_tag != ntag) begin m_stage = 0; m_mask = 0; end
      m_tag = ntag; m_tag_vld = 1;
      k = is_s ? (o / 4) % 2 : (o / 4) % 4;
      lastw = is_s ? (k == 1) : (k == 3);
      if (lastw) begin
        need = is_s ? m_mask[0] : &m_mask[2:0];
        exp_err = !need;
        if (is_s) m_sram[p * SRAM_N + (o - 'h1000) / 8] = {d, m_stage[31:0]};
        else      m_wide[p * WIDE_N + o / 16] = {d, m_stage[95:0]};
        m_mask = 0;
      end else begin
        m_stage[k*32 +: 32] = d;
        m_mask[k] = 1;
      end
    end
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    req_valid = 0;
    chk({req, " rd_valid (R2)"}, 32'(rd_valid), 32'(!w));
    if (!w) chk({req, " rd_data"}, rd_data, exp_rd);
    chk({req, " commit_err (R4)"}, 32'(commit_err), 32'(exp_err));
  endtask

  task automatic wr_wide(int p, int i, logic [127:0] v, string req);
    for (int k = 0; k < 4; k++) access(1, wa(p, i, k), v[k*32 +: 32], req);
  endtask
  task automatic rd_wide(int p, int i, string req);
    for (int k = 0; k < 4; k++) access(0, wa(p, i, k), 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int j = 0; j < PAGES*WIDE_N; j++) m_wide[j] = 0;
    for (int j = 0; j < PAGES*SRAM_N; j++) m_sram[j] = 0;
    for (int j = 0; j < PAGES*DW_N; j++)   m_dw[j] = 0;
    m_stage = 0; m_shadow = 0; m_mask = 0; m_tag = 0; m_tag_vld = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 rd_valid after reset", 32'(rd_valid), 0);
    chk("R1 commit_err after reset", 32'(commit_err), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    rd_wide(0, 1, "R1 reset contents");

    wr_wide(0, 1, 128'h44444444_33333333_22222222_11111111, "R3 full write");
    rd_wide(0, 1, "R3 readback");
    access(1, wa(0, 2, 0), 32'hAAAA0000, "R3 staged only");
    access(0, wa(0, 2, 0), 0, "R3 no early update");
    access(1, wa(0, 2, 3), 32'hAAAA0003, "R4 missing words");
    rd_wide(0, 2, "R5 zero-filled words");
    access(1, wa(0, 2, 3), 32'hBBBB0003, "R5 stale after commit");
    rd_wide(0, 2, "R5 stale readback");

    access(1, wa(0, 3, 0), 32'hC0, "R6 open A");
    access(1, wa(0, 3, 1), 32'hC1, "R6 open A");
    access(1, wa(0, 4, 1), 32'hD1, "R6 switch to B");
    access(1, wa(0, 4, 2), 32'hD2, "R6 switch to B");
    access(1, wa(0, 4, 3), 32'hD3, "R6 commit B, word0 lost");
    rd_wide(0, 4, "R6 readback");

    access(1, da(0, 0), 32'hE0, "R7 page0 word reg idle");
    wr_wide(0, 5, 128'h5, "R7 collection after word write");
    access(1, wa(0, 6, 0), 32'hF0, "R7 open");
    access(1, wa(0, 6, 1), 32'hF1, "R7 open");
    access(1, da(0, 1), 32'hE1, "R7 mid-collection");
    access(1, da(1, 2), 32'hE2, "R7 mid-collection page1");
    access(1, wa(0, 6, 2), 32'hF2, "R7 continue");
    access(1, wa(0, 6, 3), 32'hF3, "R7 commit intact");
    rd_wide(0, 6, "R7 readback");
    access(0, da(0, 1), 0, "R7 word reg value");
    access(0, da(1, 2), 0, "R7 word reg page1");

    access(0, wa(0, 1, 0), 0, "R8 snapshot");
    wr_wide(0, 1, 128'h99999999_88888888_77777777_66666666, "R8 rewrite");
    for (int k = 1; k < 4; k++) access(0, wa(0, 1, k), 0, "R8 old shadow");
    rd_wide(0, 1, "R8 fresh snapshot");

    access(1, sa(0, 2, 0), 32'h1234, "R9 lower");
    access(0, sa(0, 2, 0), 0, "R9 not committed");
    access(1, sa(0, 2, 1), 32'h5678, "R9 commit");
    access(0, sa(0, 2, 0), 0, "R9 lower read");
    access(0, sa(0, 2, 1), 0, "R9 upper read");
    access(1, sa(1, 3, 1), 32'h9, "R9 upper without lower");

    wr_wide(1, 1, 128'h1111, "R3 page1 separate");
    rd_wide(0, 1, "R3 page0 unchanged");
    access(1, wa(0, 7, 0), 32'h70, "R10 open");
    access(1, wa(0, 7, 1), 32'h71, "R10 open");
    access(1, wa(0, 7, 2), 32'h72, "R10 open");
    access(1, wa(0, WIDE_N, 0), 32'hDEAD, "R10 unmapped wide");
    access(1, da(0, 0) + 4, 32'hDEAD, "R10 unmapped slot word");
    access(1, AW'('h0FF0), 32'hDEAD, "R10 unmapped gap");
    access(1, wa(0, 7, 3), 32'h73, "R10 collection intact");
    rd_wide(0, 7, "R10 readback");
    access(0, wa(0, WIDE_N, 0), 0, "R10 read zero");
    access(0, da(0, 0) + 4, 0, "R10 read zero");
    access(0, da(0, 0), 0, "R10 word reg untouched");

    for (int n = 0; n < 3000; n++) begin
      int t = int'($urandom_range(0, 9));
      int p = int'($urandom_range(0, PAGES - 1));
      logic [31:0] d = $urandom;
      bit w = $urandom_range(0, 1) == 1;
      if (t < 5)      access(w, wa(p, int'($urandom_range(0, 2)), int'($urandom_range(0, 3))), d, "R3 R8 random wide");
      else if (t < 7) access(w, sa(p, int'($urandom_range(0, 2)), int'($urandom_range(0, 1))), d, "R9 random memory");
      else if (t < 9) access(w, da(p, int'($urandom_range(0, DW_N - 1))), d, "R7 random word reg");
      else            access(w, AW'($urandom), d, "R10 random address");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule